// File: doc/BRIEF.md
# Bridge Driver Fault and Sleep Supervisor

This block decides when the two full-bridge power stages may drive. It watches an active-low sleep request, a load-supply undervoltage flag, a charge-pump undervoltage flag, an over-temperature flag and one overcurrent flag for each bridge. From these it produces one output-disable signal shared by all bridges, a per-bridge latched overcurrent status, and a ready signal. The flags come from analog detectors outside this block, which also supply any thresholds and hysteresis. All inputs are treated as asynchronous and pass through a synchronizer of configurable depth.

Faults fall into two classes. An overcurrent on any bridge is a short and must not be retried by itself. It is latched and stays latched until the part is put to sleep or the load supply drops below its undervoltage threshold. Over-temperature and charge-pump undervoltage only block driving while they are present. Sleep and supply undervoltage stop the outputs. Whenever both are released, a start-up delay set in clock cycles runs again before driving is allowed. This gives the charge pump and regulator time to settle.

Top module: `msup_supervisor`

## Requirements
- R1: While reset is low, and at the first sample after it, out_disable is 1, ready is 0 and ocp_latched is all zeros.
- R2: A high ocp_flag bit for bridge i, seen while the part is awake and the supply is good, sets ocp_latched bit i. Bit i is the bridge with the same index. It drives out_disable high, which stops every bridge, not only bridge i.
- R3: A set ocp_latched bit stays set, and ready stays low, after its ocp_flag falls and after over-temperature or charge-pump faults come and go. It clears only when sleep_n is low or vbb_uv is high.
- R4: over_temp or vcp_uv high forces out_disable high only while the flag is present. When the flag falls, ready returns SYNC_STAGES edges later without a new start-up delay.
- R5: sleep_n low or vbb_uv high forces out_disable high and ready low.
- R6: Once sleep_n is high and vbb_uv is low, ready rises exactly SYNC_STAGES + WAKE_CYCLES clock edges later, provided no other fault is present. Any sleep or undervoltage episode in between restarts the count in full.
- R7: ready is 1 only when the part is awake, the supply is good, no fault flag is present, no overcurrent is latched and the start-up delay has expired. out_disable is always the inverse of ready.
- R8: A fault flag that rises while ready is high drives ready low exactly SYNC_STAGES edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_n | input | 1 | Active-low sleep request (asynchronous) |
| vbb_uv | input | 1 | Load-supply undervoltage flag, high = low supply |
| vcp_uv | input | 1 | Charge-pump undervoltage flag, high = fault |
| over_temp | input | 1 | Junction over-temperature flag, high = fault |
| ocp_flag | input | NUM_BRIDGES | Overcurrent flag per bridge, bit i = bridge i |
| out_disable | output | 1 | High = all bridge outputs must be off |
| ocp_latched | output | NUM_BRIDGES | Latched overcurrent status per bridge |
| ready | output | 1 | High = bridges are allowed to drive |

## Verification
Directed sequences cover the boundary cycles. A wake is checked one edge before and exactly at the end of the start-up delay, which exposes an off-by-one in the counter or in the synchronizer depth. A supply glitch in the middle of the delay separates a counter that restarts from one that only pauses. An overcurrent pulse on a single bridge, followed by a temperature fault that comes and goes, separates the latched class from the self-clearing class. Sleep and undervoltage are then each tried as the release for the latch. Random phases hold random flag combinations steady longer than the delay and compare ready, out_disable and the latch against a steady-state model. Faults are kept rare, so long runs of ready time are mixed with overlapping faults.

// File: rtl/msup_pkg.sv
// Package: shared types for the bridge driver supervisor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package msup_pkg;

    // Start-up timer phases: held off, counting, expired.
    typedef enum logic [1:0] {
        WT_OFF  = 2'd0,
        WT_WARM = 2'd1,
        WT_ON   = 2'd2
    } wake_state_t;

    // Number of single-bit supervisory flags besides the per-bridge overcurrent flags.
    localparam int unsigned MISC_FLAGS = 4;

endpackage

// File: rtl/msup_sync.sv
// Module: multi-bit multi-stage input synchronizer.
// Each bit is an independent asynchronous level; no bus coherency is assumed.
// On reset every stage loads RST_VAL so downstream logic sees a safe value.
module msup_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Later stages resolve metastability of the previous one.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

    initial begin
        if (STAGES < 1) $error("msup_sync: STAGES must be at least 1");
    end

endmodule

// File: rtl/msup_wake_timer.sv
// Module: start-up delay timer.
// Counts WAKE_CYCLES edges while power_ok is high and then raises done.
// Any low cycle of power_ok returns it to the off phase and clears the count,
// so every wake or supply recovery pays the full delay. Assumes WAKE_CYCLES >= 1.
module msup_wake_timer
    import msup_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_ok,
    output logic done
);

    localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES);

    wake_state_t   state;
    logic [CW-1:0] cnt;

    // Phase and count update: restart on loss of power, advance otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WT_OFF;
            cnt   <= '0;
        end else if (!power_ok) begin
            state <= WT_OFF;
            cnt   <= '0;
        end else begin
            case (state)
                WT_OFF: begin
                    cnt   <= CW'(1);
                    state <= (LAST == CW'(1)) ? WT_ON : WT_WARM;
                end
                WT_WARM: begin
                    cnt   <= cnt + CW'(1);
                    state <= (cnt + CW'(1) == LAST) ? WT_ON : WT_WARM;
                end
                WT_ON:   state <= WT_ON;
                default: state <= WT_OFF;
            endcase
        end
    end

    assign done = (state == WT_ON);

    // R6: the count never runs past the configured delay.
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R6: loss of power always ends an expired or running delay.
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !power_ok |=> !done);

    // R6: done can only appear after power was good on the previous edge.
    p_done_needs_power_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(power_ok));

endmodule

// File: rtl/msup_ocp_latch.sv
// Module: per-bridge overcurrent fault latch.
// A flag seen while power is good sets that bridge's bit. Only loss of power
// (sleep or supply undervoltage) clears the bit. The inputs are already synchronous.
module msup_ocp_latch #(
    parameter int unsigned NUM_BRIDGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   power_ok,
    input  logic [NUM_BRIDGES-1:0] ocp_sync,
    output logic [NUM_BRIDGES-1:0] latched
);

    generate
        for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
            // Set on overcurrent, hold until power is removed.
            always_ff @(posedge clk) begin
                if (!rst_n)           latched[b] <= 1'b0;
                else if (!power_ok)   latched[b] <= 1'b0;
                else if (ocp_sync[b]) latched[b] <= 1'b1;
            end

            // R2: an overcurrent seen with power good is held on the next edge.
            p_ocp_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (power_ok && ocp_sync[b]) |=> latched[b]);

            // R3: a held fault survives as long as power stays good.
            p_ocp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (latched[b] && power_ok) |=> latched[b]);

            // R3: loss of power releases the latch.
            p_ocp_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !power_ok |=> !latched[b]);
        end
    endgenerate

endmodule

// File: rtl/msup_supervisor.sv
// Module: bridge driver fault and sleep supervisor (top).
// Synchronizes all flags, latches overcurrent per bridge, runs the start-up
// delay after wake or supply recovery, and combines everything into one
// ready / out_disable pair that gates every bridge. Fault flags are active high;
// sleep_n is active low. Assumes NUM_BRIDGES >= 1, SYNC_STAGES >= 1, WAKE_CYCLES >= 1.
module msup_supervisor
    import msup_pkg::*;
#(
    parameter int unsigned NUM_BRIDGES = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WAKE_CYCLES = 50000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep_n,
    input  logic                   vbb_uv,
    input  logic                   vcp_uv,
    input  logic                   over_temp,
    input  logic [NUM_BRIDGES-1:0] ocp_flag,
    output logic                   out_disable,
    output logic [NUM_BRIDGES-1:0] ocp_latched,
    output logic                   ready
);

    localparam int unsigned SW = MISC_FLAGS + NUM_BRIDGES;
    // Safe reset view: asleep, supply low, no other faults.
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, 1'b0, {NUM_BRIDGES{1'b0}}};

    logic [SW-1:0]          raw_in;
    logic [SW-1:0]          sync_q;
    logic                   s_sleep_n;
    logic                   s_vbb_uv;
    logic                   s_vcp_uv;
    logic                   s_over_temp;
    logic [NUM_BRIDGES-1:0] s_ocp;
    logic                   power_ok;
    logic                   wake_done;
    logic                   soft_fault;
    logic                   hard_fault;

    assign raw_in = {sleep_n, vbb_uv, vcp_uv, over_temp, ocp_flag};

    msup_sync #(
        .WIDTH  (SW),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (sync_q)
    );

    // Unpack the synchronized flags.
    always_comb begin
        s_sleep_n   = sync_q[SW-1];
        s_vbb_uv    = sync_q[SW-2];
        s_vcp_uv    = sync_q[SW-3];
        s_over_temp = sync_q[SW-4];
        s_ocp       = sync_q[NUM_BRIDGES-1:0];
    end

    // Power is good when awake and the load supply is above its threshold.
    assign power_ok = s_sleep_n && !s_vbb_uv;

    msup_wake_timer #(
        .WAKE_CYCLES(WAKE_CYCLES)
    ) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .power_ok(power_ok),
        .done    (wake_done)
    );

    msup_ocp_latch #(
        .NUM_BRIDGES(NUM_BRIDGES)
    ) u_ocp (
        .clk     (clk),
        .rst_n   (rst_n),
        .power_ok(power_ok),
        .ocp_sync(s_ocp),
        .latched (ocp_latched)
    );

    // Fault classes: self-clearing conditions and overcurrent (live or held).
    always_comb begin
        soft_fault = s_vcp_uv || s_over_temp;
        hard_fault = (|s_ocp) || (|ocp_latched);
    end

    // Final gate shared by every bridge.
    always_comb begin
        ready       = power_ok && wake_done && !soft_fault && !hard_fault;
        out_disable = !ready;
    end

    // R5: loss of power is never followed by drive on the next edge.
    p_power_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !power_ok |=> !ready);

    // R3: a held overcurrent keeps drive off.
    p_latch_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|ocp_latched) |-> out_disable);

    // R7: drive can only start after power was already good one edge earlier.
    p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(power_ok));

    initial begin
        if (NUM_BRIDGES < 1) $error("msup_supervisor: NUM_BRIDGES must be at least 1");
        if (WAKE_CYCLES < 1) $error("msup_supervisor: WAKE_CYCLES must be at least 1");
    end

endmodule

// File: tb/msup_supervisor_bench.sv
// Bench for msup_supervisor: directed edge cases plus seeded random steady-state phases.
module msup_supervisor_bench;

    localparam int unsigned NB   = 2;
    localparam int unsigned SYNC = 2;
    localparam int unsigned WAKE = 16;
    localparam int unsigned HOLD = SYNC + WAKE + 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep_n;
    logic          vbb_uv;
    logic          vcp_uv;
    logic          over_temp;
    logic [NB-1:0] ocp_flag;
    logic          out_disable;
    logic [NB-1:0] ocp_latched;
    logic          ready;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          finished = 1'b0;

    // Bench-side model of the overcurrent latch.
    logic [NB-1:0] m_latch;

    always #2 clk = ~clk;

    msup_supervisor #(
        .NUM_BRIDGES(NB),
        .SYNC_STAGES(SYNC),
        .WAKE_CYCLES(WAKE)
    ) u_msup_supervisor (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_n    (sleep_n),
        .vbb_uv     (vbb_uv),
        .vcp_uv     (vcp_uv),
        .over_temp  (over_temp),
        .ocp_flag   (ocp_flag),
        .out_disable(out_disable),
        .ocp_latched(ocp_latched),
        .ready      (ready)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Wait n rising edges, then move to the following falling edge.
    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_ready(input string req, input logic exp);
        check(ready === exp, req, ready, exp);
        check(out_disable === !exp, {req, " out_disable"}, out_disable, !exp);
    endtask

    // Steady-state expected ready from held inputs and the latch model.
    function automatic logic exp_ready(input logic sl, input logic uv, input logic cp,
                                       input logic ot, input logic [NB-1:0] oc,
                                       input logic [NB-1:0] lat);
        return sl && !uv && !cp && !ot && (oc == '0) && (lat == '0);
    endfunction

    function automatic logic [NB-1:0] next_latch(input logic sl, input logic uv,
                                                 input logic [NB-1:0] oc,
                                                 input logic [NB-1:0] lat);
        if (!sl || uv) return '0;
        return lat | oc;
    endfunction

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        sleep_n   = 1'b0;
        vbb_uv    = 1'b1;
        vcp_uv    = 1'b0;
        over_temp = 1'b0;
        ocp_flag  = '0;
        m_latch   = '0;
        edges(3);
        // R1: reset state
        chk_ready("R1 reset", 1'b0);
        check(ocp_latched === '0, "R1 latch at reset", ocp_latched, 0);
        rst_n = 1'b1;
        edges(0);
        chk_ready("R1 after reset", 1'b0);

        // R6: wake with a good supply, exact boundary.
        sleep_n = 1'b1;
        vbb_uv  = 1'b0;
        edges(SYNC + WAKE - 1);
        chk_ready("R6 one edge before delay end", 1'b0);
        edges(1);
        chk_ready("R6 delay end", 1'b1);

        // R8/R4: over-temperature is seen after SYNC edges and releases without a delay.
        over_temp = 1'b1;
        edges(SYNC - 1);
        chk_ready("R8 before sync latency", 1'b1);
        edges(1);
        chk_ready("R8 over_temp latency", 1'b0);
        over_temp = 1'b0;
        edges(SYNC);
        chk_ready("R4 over_temp release no delay", 1'b1);

        // R4: charge-pump undervoltage behaves the same way.
        vcp_uv = 1'b1;
        edges(SYNC);
        chk_ready("R4 vcp_uv blocks", 1'b0);
        vcp_uv = 1'b0;
        edges(SYNC);
        chk_ready("R4 vcp_uv release", 1'b1);

        // R2: overcurrent pulse on bridge 1 only; both bridges disabled, bit 1 latched.
        ocp_flag = 2'b10;
        edges(SYNC);
        chk_ready("R2 ocp disables all", 1'b0);
        ocp_flag = 2'b00;
        edges(3);
        check(ocp_latched === 2'b10, "R2 latch bridge index", ocp_latched, 2'b10);

        // R3: the latch survives a temperature fault coming and going.
        over_temp = 1'b1;
        edges(4);
        over_temp = 1'b0;
        edges(HOLD);
        check(ocp_latched === 2'b10, "R3 latch holds", ocp_latched, 2'b10);
        chk_ready("R3 held latch blocks", 1'b0);

        // R3/R5: sleep clears the latch and stops drive.
        sleep_n = 1'b0;
        edges(SYNC + 1);
        check(ocp_latched === 2'b00, "R3 sleep clears latch", ocp_latched, 0);
        chk_ready("R5 asleep", 1'b0);

        // R6: wake again, then a supply glitch in mid-delay restarts the count.
        sleep_n = 1'b1;
        edges(SYNC + WAKE / 2);
        vbb_uv = 1'b1;
        edges(1);
        vbb_uv = 1'b0;
        edges(SYNC + WAKE - 1);
        chk_ready("R6 restart before end", 1'b0);
        edges(1);
        chk_ready("R6 restart full delay", 1'b1);

        // R3/R5: undervoltage also clears a latch on bridge 0.
        ocp_flag = 2'b01;
        edges(SYNC + 1);
        ocp_flag = 2'b00;
        check(ocp_latched === 2'b01, "R2 latch bridge 0", ocp_latched, 2'b01);
        vbb_uv = 1'b1;
        edges(SYNC + 1);
        check(ocp_latched === 2'b00, "R3 undervoltage clears latch", ocp_latched, 0);
        chk_ready("R5 undervoltage blocks", 1'b0);
        vbb_uv = 1'b0;
        edges(HOLD);
        chk_ready("R7 clean recovery", 1'b1);

        // R7: seeded random steady-state phases with rare faults.
        m_latch = '0;
        void'($urandom(32'h5EED_1234));
        for (int it = 0; it < 300; it++) begin
            logic          sl;
            logic          uv;
            logic          cp;
            logic          ot;
            logic [NB-1:0] oc;
            logic          er;
            sl = ($urandom % 6) != 0;
            uv = ($urandom % 6) == 0;
            cp = ($urandom % 7) == 0;
            ot = ($urandom % 7) == 0;
            oc = (($urandom % 8) == 0) ? NB'($urandom % (1 << NB)) : '0;
            sleep_n = sl; vbb_uv = uv; vcp_uv = cp; over_temp = ot; ocp_flag = oc;
            edges(HOLD);
            m_latch = next_latch(sl, uv, oc, m_latch);
            er = exp_ready(sl, uv, cp, ot, oc, m_latch);
            chk_ready("R7 random steady state", er);
            check(ocp_latched === m_latch, "R3 random latch", ocp_latched, m_latch);
        end

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule